// File: doc/BRIEF.md
# Unaligned Longword Access Merger

This block sits between a processor's 32-bit load/store port and a memory that only moves whole longwords. The processor presents a byte address, a length of two bytes (word) or four bytes (longword), a direction and, for stores, the data. The block breaks each access into fragments. One fragment lies in the longword that holds the first byte. When the access runs past that longword, a second fragment lies at the bottom of the next one. Loads come back right-aligned. Stores only change the bytes the access covers.

The address of the second longword is a separate input. Translation can place the two halves on unrelated pages, so the block never derives the second address from the first. Loads gather each fragment right-aligned and masked, then merge the fragments into one result. Stores use a masked read-modify-write on each longword they touch. The one exception is a longword store at offset zero, which overwrites the whole memory word directly.

Top module: `una_merger`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse that follows the last memory transfer of the access, and `req_ready` is high again in the next cycle.
- R2: The byte offset is bits [1:0] of `req_addr_lo`. Every memory address has bits [1:0] equal to zero. The first fragment goes to `req_addr_lo` with its two low bits cleared. The second fragment goes to `req_addr_hi` with its two low bits cleared, whatever the low bits of `req_addr_hi` hold.
- R3: An access that stays inside one longword is one fragment. These are a longword at offset 0 and a word at offset 0, 1 or 2. A load of this kind makes exactly one memory read. The addressed bytes come back right-aligned in `rdata`, and the unused upper bits are zero.
- R4: A longword load at offset k (1 to 3) takes 4-k bytes from the top of the first longword and k bytes from the bottom of the second. It returns low | (high << (32-8k)) using exactly two memory reads.
- R5: A word load at offset 3 returns byte 3 of the first longword in `rdata[7:0]` and byte 0 of the second longword in `rdata[15:8]`, using two memory reads.
- R6: Every store except an offset-0 longword store is a masked read-modify-write. For each fragment the block reads a memory longword and then writes it back. Only the bytes the access covers change. The first memory transfer after the request is taken is a read.
- R7: A longword store at offset 0 makes exactly one memory write, with `mem_wdata` equal to the request data, and no memory read.
- R8: A store that spans two longwords finishes both read-modify-write pairs before `done`. The first longword's pair comes first, and the second longword receives the remaining upper bytes of the store data in its lowest byte lanes.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. Any number of stall cycles leaves the results unchanged.
- R10: After synchronous reset the block is idle: `req_ready` is 1, `mem_req` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_long | input | 1 | 1 for a four-byte access, 0 for a two-byte access |
| req_addr_lo | input | AW | Byte address of the first byte of the access |
| req_addr_hi | input | AW | Address of the following longword (low two bits ignored) |
| req_wdata | input | 32 | Store data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Right-aligned load result, valid while `done` is high |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | AW | Longword-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the transfer in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The assertions check the handshake on every cycle. They cover the single-cycle `done` pulse and its return to idle, the alignment of every memory address, and the first fragment's address. They also check that transfers hold still through stalls, that a partial store always starts with a read, and that an offset-0 longword store goes out directly as a write. The byte lanes themselves can only be shown by the bench's scenarios. These include the merged value for each offset and length, the number of reads and writes, which bytes of memory a store leaves alone, and the use of an unrelated second longword address. The bench checks them against a byte-level memory model, first with an always-ready memory and then with one that stalls every other cycle.

// File: rtl/una_pkg.sv
package una_pkg;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = WORD_BITS / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } una_state_e;

    // one piece of an access: byte offset inside its longword and byte count
    typedef struct packed {
        logic [1:0] boff;
        logic [2:0] nbytes;
    } frag_t;

    typedef struct packed {
        frag_t lo;      // piece in the longword holding the first byte
        frag_t hi;      // piece at the bottom of the next longword
        logic  split;   // access needs both pieces
        logic  whole;   // aligned four-byte access
    } plan_t;

    function automatic logic [WORD_BITS-1:0] lane_mask(input logic [2:0] n);
        logic [WORD_BITS-1:0] m;
        case (n)
            3'd1:    m = 32'h0000_00FF;
            3'd2:    m = 32'h0000_FFFF;
            3'd3:    m = 32'h00FF_FFFF;
            3'd4:    m = 32'hFFFF_FFFF;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic plan_t plan_of(input logic [1:0] off, input logic is_long);
        plan_t      p;
        logic [2:0] total;
        logic [2:0] reach;
        total  = is_long ? 3'd4 : 3'd2;
        reach  = {1'b0, off} + total;
        p      = '0;
        p.lo.boff = off;
        p.whole   = is_long && (off == 2'd0);
        if (reach > 3'd4) begin
            p.split     = 1'b1;
            p.lo.nbytes = 3'd4 - {1'b0, off};
            p.hi.boff   = 2'd0;
            p.hi.nbytes = reach - 3'd4;
        end else begin
            p.lo.nbytes = total;
        end
        return p;
    endfunction

endpackage

// File: rtl/una_plan.sv
module una_plan
    import una_pkg::*;
(
    input  logic [1:0] offset,
    input  logic       is_long,
    output plan_t      plan
);
    always_comb plan = plan_of(offset, is_long);
endmodule

// File: rtl/una_lane.sv
module una_lane
    import una_pkg::*;
(
    input  logic [WORD_BITS-1:0] word_in,
    input  frag_t                frag,
    input  logic [WORD_BITS-1:0] val,
    output logic [WORD_BITS-1:0] extracted,
    output logic [WORD_BITS-1:0] merged
);
    logic [4:0]           shamt;
    logic [WORD_BITS-1:0] m;

    always_comb begin
        shamt     = {frag.boff, 3'b000};
        m         = lane_mask(frag.nbytes);
        extracted = (word_in >> shamt) & m;
        merged    = (word_in & ~(m << shamt)) | ((val & m) << shamt);
    end
endmodule

// File: rtl/una_merger.sv
module una_merger
    import una_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_long,
    input  logic [AW-1:0]        req_addr_lo,
    input  logic [AW-1:0]        req_addr_hi,
    input  logic [WORD_BITS-1:0] req_wdata,
    output logic                 done,
    output logic [WORD_BITS-1:0] rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata
);
    localparam int LW_BITS = AW - 2;

    una_state_e           state_q;
    plan_t                plan_in, plan_q;
    logic                 idx_q, we_q;
    logic [LW_BITS-1:0]   lw_lo_q, lw_hi_q;
    logic [WORD_BITS-1:0] wdata_q, wbuf_q, acc_q;

    frag_t                cur_frag;
    logic [WORD_BITS-1:0] cur_val, ext, mrg, ext_placed;
    logic [5:0]           lo_bits;

    una_plan u_plan (
        .offset  (req_addr_lo[1:0]),
        .is_long (req_long),
        .plan    (plan_in)
    );

    always_comb begin
        lo_bits    = {plan_q.lo.nbytes, 3'b000};
        cur_frag   = idx_q ? plan_q.hi : plan_q.lo;
        cur_val    = idx_q ? (wdata_q >> lo_bits) : wdata_q;
        ext_placed = idx_q ? (ext << lo_bits) : ext;
    end

    una_lane u_lane (
        .word_in   (mem_rdata),
        .frag      (cur_frag),
        .val       (cur_val),
        .extracted (ext),
        .merged    (mrg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            plan_q  <= '0;
            idx_q   <= 1'b0;
            we_q    <= 1'b0;
            lw_lo_q <= '0;
            lw_hi_q <= '0;
            wdata_q <= '0;
            wbuf_q  <= '0;
            acc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        plan_q  <= plan_in;
                        we_q    <= req_write;
                        idx_q   <= 1'b0;
                        lw_lo_q <= req_addr_lo[AW-1:2];
                        lw_hi_q <= req_addr_hi[AW-1:2];
                        wdata_q <= req_wdata;
                        wbuf_q  <= req_wdata;
                        acc_q   <= '0;
                        state_q <= (req_write && plan_in.whole) ? ST_WRITE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (we_q) begin
                            wbuf_q  <= mrg;
                            state_q <= ST_WRITE;
                        end else begin
                            acc_q <= acc_q | ext_placed;
                            if (!idx_q && plan_q.split) idx_q   <= 1'b1;
                            else                        state_q <= ST_DONE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        if (!idx_q && plan_q.split) begin
                            idx_q   <= 1'b1;
                            state_q <= ST_READ;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        rdata     = acc_q;
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = {(idx_q ? lw_hi_q : lw_lo_q), 2'b00};
        mem_wdata = wbuf_q;
    end

endmodule

// File: rtl/una_merger_chk.sv
module una_merger_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          req_long,
    input logic [AW-1:0] req_addr_lo,
    input logic [31:0]   req_wdata,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack
);
    logic take;
    logic full_store;
    assign take       = req_valid && req_ready;
    assign full_store = req_write && req_long && (req_addr_lo[1:0] == 2'b00);

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !done));

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r2_first_addr: assert property (@(posedge clk) disable iff (rst)
        take |=> (mem_req && mem_addr[AW-1:2] == $past(req_addr_lo[AW-1:2])));

    a_r3_load_reads: assert property (@(posedge clk) disable iff (rst)
        (take && !req_write) |=> (mem_req && !mem_we));

    a_r6_read_first: assert property (@(posedge clk) disable iff (rst)
        (take && req_write && !full_store) |=> (mem_req && !mem_we));

    a_r7_direct_write: assert property (@(posedge clk) disable iff (rst)
        (take && full_store) |=> (mem_req && mem_we && mem_wdata == $past(req_wdata)));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
endmodule

bind una_merger una_merger_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_long    (req_long),
    .req_addr_lo (req_addr_lo),
    .req_wdata   (req_wdata),
    .done        (done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack)
);

// File: tb/sim_una_merger.sv
module sim_una_merger;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NVEC = 15;

    // {write, long, addr_lo, addr_hi, wdata}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h10, 8'h14, 32'h0},
        {1'b0, 1'b1, 8'h11, 8'h14, 32'h0},
        {1'b0, 1'b1, 8'h12, 8'h14, 32'h0},
        {1'b0, 1'b1, 8'h13, 8'h83, 32'h0},
        {1'b0, 1'b0, 8'h20, 8'h24, 32'h0},
        {1'b0, 1'b0, 8'h21, 8'h24, 32'h0},
        {1'b0, 1'b0, 8'h22, 8'h24, 32'h0},
        {1'b0, 1'b0, 8'h23, 8'h42, 32'h0},
        {1'b1, 1'b1, 8'h30, 8'h34, 32'hDEADBEEF},
        {1'b1, 1'b1, 8'h31, 8'h50, 32'h11223344},
        {1'b1, 1'b1, 8'h37, 8'h3B, 32'hA5B6C7D8},
        {1'b1, 1'b0, 8'h45, 8'h48, 32'h0000CAFE},
        {1'b1, 1'b0, 8'h4B, 8'h61, 32'h00001234},
        {1'b1, 1'b1, 8'h1A, 8'h9D, 32'h87654321},
        {1'b0, 1'b1, 8'h1A, 8'h9D, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_long = 1'b0;
    logic [AW-1:0] req_addr_lo = '0;
    logic [AW-1:0] req_addr_hi = '0;
    logic [31:0]   req_wdata = '0;
    logic          done;
    logic [31:0]   rdata;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    logic [31:0]   mem [64];
    logic [7:0]    shadow [256];
    logic          stall_en = 1'b0;
    logic          stall_ph;
    int            rd_cnt, wr_cnt;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ack   = mem_req && (!stall_en || stall_ph);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++)
                mem[i] <= {8'(i) ^ 8'hA5, 8'(i) + 8'h40, ~8'(i), 8'(i * 3)};
            stall_ph <= 1'b0;
            rd_cnt   <= 0;
            wr_cnt   <= 0;
        end else begin
            stall_ph <= ~stall_ph;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[7:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    una_merger #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_long(req_long), .req_addr_lo(req_addr_lo),
        .req_addr_hi(req_addr_hi), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int byte_addr(input logic [7:0] a0, input logic [7:0] a1, input int j);
        if (j < 4) return {a0[7:2], 2'b00} + j;
        return {a1[7:2], 2'b00} + j - 4;
    endfunction

    task automatic run_vec(input logic [49:0] v, input string tag);
        logic        we, lng;
        logic [7:0]  a0, a1;
        logic [31:0] wd, expd, got;
        int          n, k, frags, r0, w0, exp_rd, exp_wr;
        {we, lng, a0, a1, wd} = v;
        n = lng ? 4 : 2;
        k = int'(a0[1:0]);
        frags = (k + n > 4) ? 2 : 1;
        exp_rd = (we && k == 0 && n == 4) ? 0 : frags;
        exp_wr = we ? frags : 0;
        expd = '0;
        for (int i = 0; i < n; i++) begin
            if (we) shadow[byte_addr(a0, a1, k + i)] = wd[8*i +: 8];
            else    expd[8*i +: 8] = shadow[byte_addr(a0, a1, k + i)];
        end
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1'b1; req_write = we; req_long = lng;
        req_addr_lo = a0; req_addr_hi = a1; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got = rdata;
        if (!we) check(got === expd, {tag, " load data R3 R4 R5 R9"}, got, expd);
        @(negedge clk);
        check(!done && req_ready, {tag, " R1 done pulse and ready"}, {30'b0, done, req_ready}, 32'h1);
        check(rd_cnt - r0 == exp_rd, {tag, " read count R3 R4 R6 R7"}, rd_cnt - r0, exp_rd);
        check(wr_cnt - w0 == exp_wr, {tag, " write count R6 R7 R8"}, wr_cnt - w0, exp_wr);
        if (we) begin
            int bad = 0;
            for (int i = 0; i < 64; i++)
                for (int b = 0; b < 4; b++)
                    if (mem[i][8*b +: 8] !== shadow[4*i + b]) bad++;
            check(bad == 0, {tag, " memory image R6 R8 R2"}, bad, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++)
            for (int b = 0; b < 4; b++)
                shadow[4*i + b] = mem[i][8*b +: 8];
        // R10: reset state
        check(req_ready && !mem_req && !done, "R10 reset state",
              {29'b0, req_ready, mem_req, done}, 32'h4);
        // table walk with an always-ready memory
        for (int t = 0; t < NVEC; t++) run_vec(VEC[t], $sformatf("vec%0d", t));
        // R9: same kinds of access against a memory that stalls every other cycle
        stall_en = 1'b1;
        run_vec(VEC[1], "stall long off1");
        run_vec(VEC[7], "stall word off3");
        run_vec(VEC[10], "stall store long off3");
        run_vec(VEC[12], "stall store word off3");
        run_vec({1'b0, 1'b1, 8'h37, 8'h3B, 32'h0}, "stall readback R8");
        stall_en = 1'b0;
        // R2: second longword taken from addr_hi even when far from addr_lo
        run_vec({1'b0, 1'b1, 8'h4B, 8'h61, 32'h0}, "R2 page cross readback");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule